// File: doc/BRIEF.md
# Low-Side Channel Fault Collector

This block gathers the protection indications of a bank of low-side output channels into one fault word and one active-low fault pin. Each channel has an overcurrent comparator level and an open-load comparator level. Each level must stay high for a programmable number of clock cycles before it is taken as a fault. A confirmed overcurrent forces its channel off and holds it off until the flag is cleared.

The flags clear themselves when the host writes the opposite state into the channel's output data bit. A data bit of 0 clears overcurrent, and a data bit of 1 clears open-load. A fault-reset strobe clears every flag at once. Over-temperature shuts all channels down and pulls the fault pin low only while the temperature flag is high. Undervoltage returns the whole block to its reset state and keeps the fault pin released.

All outputs are registered. A change on the inputs sampled at one rising edge appears on the outputs right after that edge. The deglitch windows are the only exception.

Top module: `chflt_unit`

## Requirements
- R1: After reset, `fault_reg_o` is all zero, `force_off_o` is all zero, `all_off_o` is 0 and `fault_n_o` is 1.
- R2: Bit i of `fault_reg_o` (i from 0 to CH-1) is the open-load flag of channel i. Bit CH+i is the overcurrent flag of channel i.
- R3: A confirmed overcurrent on channel i sets bit CH+i, sets `force_off_o[i]` and drives `fault_n_o` low, all on the same edge. `force_off_o[i]` stays 1 while the flag is set, even after the comparator level falls and while `data_i[i]` stays 1.
- R4: An overcurrent is confirmed only after `oc_raw_i[i]` has been high with `data_i[i]` = 1 at OC_DG consecutive rising edges. A shorter pulse leaves no trace.
- R5: An open-load is confirmed only after `ol_raw_i[i]` has been high with `data_i[i]` = 0 at OL_DG consecutive rising edges. While `data_i[i]` = 1, the open-load level is ignored.
- R6: A rising edge that samples `data_i[i]` = 0 clears the overcurrent flag of channel i and releases `force_off_o[i]`.
- R7: A rising edge that samples `data_i[i]` = 1 clears the open-load flag of channel i.
- R8: A rising edge that samples `flt_clr_i` = 1 clears every flag that is not being set on that same edge.
- R9: When a flag is set and cleared on the same edge, the set wins.
- R10: `fault_n_o` is 0 whenever any fault bit is 1 or over-temperature is active. It returns to 1 only when all 2*CH bits are 0.
- R11: The edge after `otemp_i` is sampled high sets `all_off_o` = 1 and `fault_n_o` = 0. Both return to their idle values on the edge after `otemp_i` is sampled low, with no further action.
- R12: While `uv_i` is sampled high, every register, including the deglitch counters, returns to its reset state. `fault_n_o` stays 1 even if over-temperature is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| uv_i | input | 1 | Undervoltage, acts as a synchronous reset of all logic |
| oc_raw_i | input | CH | Per-channel overcurrent comparator levels |
| ol_raw_i | input | CH | Per-channel open-load comparator levels |
| data_i | input | CH | Output data register, 1 = channel commanded on |
| flt_clr_i | input | 1 | Fault-reset strobe, clears all flags |
| otemp_i | input | 1 | Over-temperature flag |
| fault_reg_o | output | 2*CH | Overcurrent flags in the upper half, open-load flags in the lower half |
| force_off_o | output | CH | Per-channel forced shutdown caused by overcurrent |
| all_off_o | output | 1 | Global output disable during over-temperature |
| fault_n_o | output | 1 | Active-low fault indication |

## Verification
The bench builds the block with CH = 8, OC_DG = 3 and OL_DG = 5. Short windows put both deglitch boundaries within a few cycles, so the bench can observe one edge short of the window and exactly at it. Because the two windows differ, an overcurrent and an open-load started together confirm on different edges, and the bench can place both flags in the word at once. The bench also holds a confirmed open-load level high through a fault reset, which exercises the case where a set and a clear land on the same edge.

// File: rtl/chflt_pkg.sv
package chflt_pkg;

  // Action applied to one fault flag on a clock edge
  typedef enum logic [1:0] {
    FL_HOLD  = 2'd0,
    FL_SET   = 2'd1,
    FL_CLEAR = 2'd2
  } flag_act_e;

  // Next flag value for a decided action
  function automatic logic flag_next(flag_act_e act, logic cur);
    case (act)
      FL_SET:   return 1'b1;
      FL_CLEAR: return 1'b0;
      default:  return cur;
    endcase
  endfunction

  // Width needed to count from 0 up to lim inclusive
  function automatic int unsigned cnt_width(int unsigned lim);
    return (lim < 1) ? 1 : $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/chflt_persist.sv
// Persistence filter: hit_o is high while lvl_i is high at the LIMIT-th
// consecutive sampling edge or later.
module chflt_persist
  import chflt_pkg::*;
#(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk_i,
  input  logic clr_i,
  input  logic lvl_i,
  output logic hit_o
);
  localparam int unsigned CW = cnt_width(LIMIT);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i) begin
    if (clr_i || !lvl_i) begin
      run_q <= '0;
    end else if (run_q != TOP) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign hit_o = lvl_i && (run_q >= LAST);

endmodule

// File: rtl/chflt_lane.sv
// One channel: two filtered flags with their set/clear rules.
module chflt_lane
  import chflt_pkg::*;
#(
  parameter int unsigned OC_DG = 4,
  parameter int unsigned OL_DG = 17
) (
  input  logic clk_i,
  input  logic clr_i,
  input  logic oc_raw_i,
  input  logic ol_raw_i,
  input  logic data_i,
  input  logic flt_clr_i,
  output logic oc_q_o,
  output logic ol_q_o,
  output logic oc_nxt_o,
  output logic ol_nxt_o
);
  logic oc_hit, ol_hit;
  flag_act_e oc_act, ol_act;
  logic oc_q, ol_q;

  // Overcurrent is only meaningful while the channel is commanded on
  chflt_persist #(.LIMIT(OC_DG)) u_oc_filt (
    .clk_i (clk_i),
    .clr_i (clr_i),
    .lvl_i (oc_raw_i && data_i),
    .hit_o (oc_hit)
  );

  // Open-load is only evaluated while the channel is commanded off
  chflt_persist #(.LIMIT(OL_DG)) u_ol_filt (
    .clk_i (clk_i),
    .clr_i (clr_i),
    .lvl_i (ol_raw_i && !data_i),
    .hit_o (ol_hit)
  );

  // Set has priority over every clear source
  always_comb begin
    oc_act = FL_HOLD;
    if (oc_hit) begin
      oc_act = FL_SET;
    end else if (flt_clr_i || !data_i) begin
      oc_act = FL_CLEAR;
    end

    ol_act = FL_HOLD;
    if (ol_hit) begin
      ol_act = FL_SET;
    end else if (flt_clr_i || data_i) begin
      ol_act = FL_CLEAR;
    end
  end

  assign oc_nxt_o = flag_next(oc_act, oc_q);
  assign ol_nxt_o = flag_next(ol_act, ol_q);

  always_ff @(posedge clk_i) begin
    if (clr_i) begin
      oc_q <= 1'b0;
      ol_q <= 1'b0;
    end else begin
      oc_q <= oc_nxt_o;
      ol_q <= ol_nxt_o;
    end
  end

  assign oc_q_o = oc_q;
  assign ol_q_o = ol_q;

endmodule

// File: rtl/chflt_summary.sv
// Registered fault pin and global disable, aligned with the flag registers.
module chflt_summary (
  input  logic clk_i,
  input  logic clr_i,
  input  logic any_nxt_i,
  input  logic otemp_i,
  output logic fault_n_o,
  output logic all_off_o
);
  always_ff @(posedge clk_i) begin
    if (clr_i) begin
      fault_n_o <= 1'b1;
      all_off_o <= 1'b0;
    end else begin
      fault_n_o <= !(any_nxt_i || otemp_i);
      all_off_o <= otemp_i;
    end
  end
endmodule

// File: rtl/chflt_unit.sv
module chflt_unit #(
  parameter int unsigned CH    = 8,
  parameter int unsigned OC_DG = 4,
  parameter int unsigned OL_DG = 17
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            uv_i,
  input  logic [CH-1:0]   oc_raw_i,
  input  logic [CH-1:0]   ol_raw_i,
  input  logic [CH-1:0]   data_i,
  input  logic            flt_clr_i,
  input  logic            otemp_i,
  output logic [2*CH-1:0] fault_reg_o,
  output logic [CH-1:0]   force_off_o,
  output logic            all_off_o,
  output logic            fault_n_o
);
  localparam int unsigned FW = 2 * CH;

  logic          clr_all;
  logic [CH-1:0] oc_q, ol_q, oc_nxt, ol_nxt;
  logic [FW-1:0] word_nxt;

  assign clr_all = rst_i || uv_i;

  for (genvar g = 0; g < CH; g++) begin : g_lane
    chflt_lane #(.OC_DG(OC_DG), .OL_DG(OL_DG)) u_lane (
      .clk_i     (clk_i),
      .clr_i     (clr_all),
      .oc_raw_i  (oc_raw_i[g]),
      .ol_raw_i  (ol_raw_i[g]),
      .data_i    (data_i[g]),
      .flt_clr_i (flt_clr_i),
      .oc_q_o    (oc_q[g]),
      .ol_q_o    (ol_q[g]),
      .oc_nxt_o  (oc_nxt[g]),
      .ol_nxt_o  (ol_nxt[g])
    );
  end

  assign word_nxt = {oc_nxt, ol_nxt};

  chflt_summary u_sum (
    .clk_i     (clk_i),
    .clr_i     (clr_all),
    .any_nxt_i (|word_nxt),
    .otemp_i   (otemp_i),
    .fault_n_o (fault_n_o),
    .all_off_o (all_off_o)
  );

  assign fault_reg_o = {oc_q, ol_q};
  assign force_off_o = oc_q;

endmodule

// File: rtl/chflt_unit_chk.sv
module chflt_unit_chk #(
  parameter int unsigned CH = 8
) (
  input logic            clk_i,
  input logic            rst_i,
  input logic            uv_i,
  input logic [CH-1:0]   oc_raw_i,
  input logic [CH-1:0]   ol_raw_i,
  input logic [CH-1:0]   data_i,
  input logic            flt_clr_i,
  input logic            otemp_i,
  input logic [2*CH-1:0] fault_reg_o,
  input logic [CH-1:0]   force_off_o,
  input logic            all_off_o,
  input logic            fault_n_o
);
  // R4: a new overcurrent bit needs a qualified comparator level on the edge before
  a_r4_oc_needs_level: assert property (@(posedge clk_i) disable iff (rst_i || uv_i)
    1'b1 |=> ((fault_reg_o[2*CH-1:CH] & ~$past(fault_reg_o[2*CH-1:CH])
               & ~($past(oc_raw_i) & $past(data_i))) == '0));

  // R5: a new open-load bit needs the level while the channel was commanded off
  a_r5_ol_needs_level: assert property (@(posedge clk_i) disable iff (rst_i || uv_i)
    1'b1 |=> ((fault_reg_o[CH-1:0] & ~$past(fault_reg_o[CH-1:0])
               & ~($past(ol_raw_i) & ~$past(data_i))) == '0));

  // R6: overcurrent flags cannot survive an edge that saw data 0
  a_r6_oc_clear: assert property (@(posedge clk_i) disable iff (rst_i || uv_i)
    1'b1 |=> ((fault_reg_o[2*CH-1:CH] & ~$past(data_i)) == '0));

  // R7: open-load flags cannot survive an edge that saw data 1
  a_r7_ol_clear: assert property (@(posedge clk_i) disable iff (rst_i || uv_i)
    1'b1 |=> ((fault_reg_o[CH-1:0] & $past(data_i)) == '0));

  // R3: forced shutdown is released only by data 0 or a fault reset
  a_r3_force_hold: assert property (@(posedge clk_i) disable iff (rst_i || uv_i)
    1'b1 |=> (($past(force_off_o) & ~force_off_o & $past(data_i)
               & {CH{!$past(flt_clr_i)}}) == '0));

  // R8: a fault reset with all levels low leaves an empty fault word
  a_r8_clear_all: assert property (@(posedge clk_i) disable iff (rst_i || uv_i)
    (flt_clr_i && !(|oc_raw_i) && !(|ol_raw_i)) |=> (fault_reg_o == '0));

  // R10: fault pin agrees with the fault word and the global disable
  a_r10_pin_agrees: assert property (@(posedge clk_i) disable iff (rst_i || uv_i)
    fault_n_o == !((|fault_reg_o) || all_off_o));

  // R11: over-temperature shuts everything off and pulls the pin low
  a_r11_otemp: assert property (@(posedge clk_i) disable iff (rst_i || uv_i)
    otemp_i |=> (all_off_o && !fault_n_o));

  // R12: undervoltage restores the idle state with the pin released
  a_r12_uv_idle: assert property (@(posedge clk_i) disable iff (rst_i)
    uv_i |=> (fault_reg_o == '0 && fault_n_o && !all_off_o));

endmodule

bind chflt_unit chflt_unit_chk #(.CH(CH)) u_chflt_chk (.*);

// File: tb/test_chflt_unit.sv
module test_chflt_unit;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned CH = 8;

  typedef struct {
    logic [15:0] word;
    logic        pin_n;
    logic        off;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1, uv = 1'b0, clr = 1'b0, ot = 1'b0;
  logic [CH-1:0] oc = '0, ol = '0, dat = '0;
  logic [2*CH-1:0] word;
  logic [CH-1:0] force_off;
  logic all_off, fault_n;

  exp_t sb_q[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chflt_unit #(.CH(CH), .OC_DG(3), .OL_DG(5)) i_chflt_unit (
    .clk_i(clk), .rst_i(rst), .uv_i(uv), .oc_raw_i(oc), .ol_raw_i(ol),
    .data_i(dat), .flt_clr_i(clr), .otemp_i(ot), .fault_reg_o(word),
    .force_off_o(force_off), .all_off_o(all_off), .fault_n_o(fault_n)
  );

  // Driver side: apply inputs away from the rising edge
  task automatic drive(logic [7:0] d, logic [7:0] o_c, logic [7:0] o_l,
                       logic fr, logic t, logic u);
    @(negedge clk);
    dat = d; oc = o_c; ol = o_l; clr = fr; ot = t; uv = u;
  endtask

  // Driver side: after n rising edges, post what the outputs must show
  task automatic expect_after(int n, logic [15:0] w, logic pn, logic ao, string tag);
    exp_t e;
    repeat (n) @(posedge clk);
    #1;
    e.word = w; e.pin_n = pn; e.off = ao; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: compare pending expectations at the falling edge
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (word !== e.word || fault_n !== e.pin_n || all_off !== e.off ||
          force_off !== e.word[15:8]) begin
        fails++;
        $display("FAIL %s: word=%h pin_n=%b off=%b force=%h expected word=%h pin_n=%b off=%b force=%h",
                 e.tag, word, fault_n, all_off, force_off,
                 e.word, e.pin_n, e.off, e.word[15:8]);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    drive(8'h00, 8'h00, 8'h00, 0, 0, 0);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    expect_after(1, 16'h0000, 1, 0, "R1 reset state");

    // R4: two-cycle overcurrent pulse is filtered out
    drive(8'h04, 8'h04, 8'h00, 0, 0, 0);
    expect_after(2, 16'h0000, 1, 0, "R4 short pulse");
    drive(8'h04, 8'h00, 8'h00, 0, 0, 0);
    expect_after(3, 16'h0000, 1, 0, "R4 pulse left no trace");

    // R3/R4: full window confirms on channel 2
    drive(8'h04, 8'h04, 8'h00, 0, 0, 0);
    expect_after(2, 16'h0000, 1, 0, "R4 one edge short");
    expect_after(1, 16'h0400, 0, 0, "R3 overcurrent confirmed");
    drive(8'h04, 8'h00, 8'h00, 0, 0, 0);
    expect_after(3, 16'h0400, 0, 0, "R3 force-off sticky with data 1");

    // R6: data 0 clears overcurrent
    drive(8'h00, 8'h00, 8'h00, 0, 0, 0);
    expect_after(1, 16'h0000, 1, 0, "R6 data 0 clears overcurrent");

    // R5: channel 5 off confirms, channel 6 on is ignored
    drive(8'h40, 8'h00, 8'h60, 0, 0, 0);
    expect_after(4, 16'h0000, 1, 0, "R5 open-load window not reached");
    expect_after(1, 16'h0020, 0, 0, "R5 open-load confirmed");
    expect_after(6, 16'h0020, 0, 0, "R5 level ignored while data 1");

    // R7: data 1 clears open-load
    drive(8'h60, 8'h00, 8'h00, 0, 0, 0);
    expect_after(1, 16'h0000, 1, 0, "R7 data 1 clears open-load");

    // R2: both kinds at once, then R8 fault reset
    drive(8'h01, 8'h01, 8'h80, 0, 0, 0);
    expect_after(5, 16'h0180, 0, 0, "R2 bit layout");
    drive(8'h01, 8'h00, 8'h00, 1, 0, 0);
    expect_after(1, 16'h0000, 1, 0, "R8 fault reset");
    drive(8'h01, 8'h00, 8'h00, 0, 0, 0);

    // R9: set wins over a reset on the same edge
    drive(8'h00, 8'h00, 8'h08, 0, 0, 0);
    expect_after(5, 16'h0008, 0, 0, "R5 channel 3 confirmed");
    drive(8'h00, 8'h00, 8'h08, 1, 0, 0);
    expect_after(1, 16'h0008, 0, 0, "R9 set beats reset");
    drive(8'h00, 8'h00, 8'h00, 1, 0, 0);
    expect_after(1, 16'h0000, 1, 0, "R8 reset with levels low");
    drive(8'h00, 8'h00, 8'h00, 0, 0, 0);

    // R11: over-temperature
    drive(8'h00, 8'h00, 8'h00, 0, 1, 0);
    expect_after(1, 16'h0000, 0, 1, "R11 over-temperature shutdown");
    drive(8'h00, 8'h00, 8'h00, 0, 0, 0);
    expect_after(1, 16'h0000, 1, 0, "R11 automatic release");

    // R10: pin held until the last bit clears
    drive(8'h00, 8'h00, 8'h18, 0, 0, 0);
    expect_after(5, 16'h0018, 0, 0, "R10 two flags");
    drive(8'h08, 8'h00, 8'h10, 0, 0, 0);
    expect_after(1, 16'h0010, 0, 0, "R10 one flag left keeps pin low");
    drive(8'h18, 8'h00, 8'h00, 0, 0, 0);
    expect_after(1, 16'h0000, 1, 0, "R10 all clear releases pin");

    // R12: undervoltage wipes state, pin stays released
    drive(8'h00, 8'h00, 8'h02, 0, 0, 0);
    expect_after(5, 16'h0002, 0, 0, "R12 setup flag");
    drive(8'h00, 8'h00, 8'h02, 0, 1, 1);
    expect_after(1, 16'h0000, 1, 0, "R12 undervoltage reset");
    expect_after(3, 16'h0000, 1, 0, "R12 held with over-temperature");
    drive(8'h00, 8'h00, 8'h00, 0, 0, 0);
    expect_after(2, 16'h0000, 1, 0, "R12 after release");

    repeat (3) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule